// File: doc/BRIEF.md
# Flash shadow row access controller

This block sits between a bus slave port and a flash store. It sends each read either to the main array or to a small 256-byte shadow row. The choice comes from an alias-enable bit in a three-bit control register. When the alias is on, a supervisor data read of any array address returns the shadow word chosen by byte-address bits 7 down to 2. User-mode accesses and instruction fetches get an error response instead. Accesses that select the control register always reach the register, whatever the alias state.

The control register holds three bits: alias enable, a guard bit and a programming enable. While the guard bit is set and programming is disabled, the alias-enable bit cannot be written. Program writes use the same path as reads. They land in the shadow row when the alias is on and in the main array when it is off. Writes to the first four shadow words are discarded.

A read-page monitor records the 32-byte page of the last read. A read that hits this page completes in one cycle. A read that misses takes two extra wait cycles. Any change of the alias bit, and any program write, clears the monitor.

Top module: `flash_alias_ctl`

## Requirements
- R1: After reset the control register reads 0 (alias off), the response outputs are low, and every word of both memories reads 0.
- R2: A request with `req_ctrl`=1 always reaches the control register, whatever the alias state. The register fields are: bit 0 alias enable, bit 1 guard, bit 2 program enable. Read data bits above 2 are 0.
- R3: A control write leaves alias enable unchanged when the guard and program-enable values held before the write are 1 and 0. The guard and program-enable bits are still updated by that write.
- R4: With the alias on, a supervisor data read at any array address returns shadow word `addr[7:2]`.
- R5: With the alias off, a read returns array word `addr[ADDR_W-1:2]`.
- R6: A write with program enable set stores into the shadow row when the alias is on and into the array when it is off. With program enable clear, a write changes neither memory.
- R7: Writes to shadow words 0 to 3 (the first 16 bytes) are ignored. Reads of those words return the stored value.
- R8: With the alias on, a user-mode access (`req_super`=0) or an instruction fetch (`req_data`=0) to the array gets `rsp_err`=1 with read data 0. It has no effect on either memory or on the page monitor.
- R9: `rsp_ready` is a one-cycle pulse. It comes 1 cycle after acceptance for on-page reads, writes, control accesses and errors, and 3 cycles after acceptance for off-page reads. `rsp_offpage` is 1 with the pulse exactly for off-page reads.
- R10: A read is on-page when its page `addr[ADDR_W-1:5]` equals the page of the last accepted read since the monitor was last cleared. The first read after reset is off-page.
- R11: A change of alias enable, or any accepted non-error write to the array space, clears the page monitor, so the next read is off-page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_ctrl | input | 1 | 1 selects the control register, 0 selects the array space |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_super | input | 1 | 1 for a supervisor access |
| req_data | input | 1 | 1 for a data access, 0 for an instruction fetch |
| req_addr | input | ADDR_W-2 | Byte-address bits ADDR_W-1 down to 2 |
| req_wdata | input | DATA_W | Write data |
| rsp_ready | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_ready |
| rsp_err | output | 1 | Error response, valid with rsp_ready |
| rsp_offpage | output | 1 | The completed read missed the page monitor |

## Verification
The bench builds the block with its default parameters: a 10-bit byte address (a 256-word array), 32-bit data and two extra wait cycles. With a 10-bit address, addresses 0x050 and 0x350 both alias to shadow word 20 while they fall in different read pages. One walk of the stimulus table therefore covers aliasing, page hits and misses, and monitor clearing. The same walk checks the guard rule, where the pre-write values of the guard and program-enable bits decide the outcome, along with the reserved shadow words and the error path. A reset in the middle of the run shows that the register, the memories and the monitor all return to their reset state.

// File: rtl/flash_alias_pkg.sv
package flash_alias_pkg;

  localparam int CTRL_BITS = 3;
  localparam int ALIAS_BIT = 0;
  localparam int GUARD_BIT = 1;
  localparam int PGM_BIT   = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RESP
  } xfer_state_e;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CTRL_RD,
    RK_ARRAY_RD,
    RK_SHADOW_RD,
    RK_WRITE,
    RK_ERROR
  } resp_kind_e;

  // Alias enable may be written unless guarded with programming disabled.
  function automatic logic alias_write_allowed(input logic guard, input logic pgm);
    return !(guard && !pgm);
  endfunction

endpackage

// File: rtl/fa_sram.sv
module fa_sram #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      q <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      if (re) q <= mem[raddr];
    end
  end

endmodule

// File: rtl/fa_ctrl_reg.sv
module fa_ctrl_reg
  import flash_alias_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CTRL_BITS-1:0] wr_val,
  output logic                 alias_en,
  output logic                 guard,
  output logic                 pgm_en,
  output logic                 alias_change
);

  logic alias_ok;

  assign alias_ok     = alias_write_allowed(guard, pgm_en);
  assign alias_change = wr_en && alias_ok && (wr_val[ALIAS_BIT] != alias_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alias_en <= 1'b0;
      guard    <= 1'b0;
      pgm_en   <= 1'b0;
    end else if (wr_en) begin
      guard  <= wr_val[GUARD_BIT];
      pgm_en <= wr_val[PGM_BIT];
      if (alias_ok) alias_en <= wr_val[ALIAS_BIT];
    end
  end

  // R3: a guarded write with programming off leaves the alias bit alone
  p_alias_guarded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && guard && !pgm_en) |=> $stable(alias_en));

endmodule

// File: rtl/fa_page_mon.sv
module fa_page_mon #(
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             update,
  input  logic [TAG_W-1:0] probe_tag,
  output logic             off_page
);

  logic             valid_q;
  logic [TAG_W-1:0] tag_q;

  assign off_page = !valid_q || (tag_q != probe_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (flush) begin
      valid_q <= 1'b0;
    end else if (update) begin
      valid_q <= 1'b1;
      tag_q   <= probe_tag;
    end
  end

endmodule

// File: rtl/flash_alias_ctl.sv
module flash_alias_ctl
  import flash_alias_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 32,
  parameter int SHADOW_BYTES = 256,
  parameter int RSV_BYTES    = 16,
  parameter int PAGE_BYTES   = 32,
  parameter int EXTRA_WAIT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_ctrl,
  input  logic              req_write,
  input  logic              req_super,
  input  logic              req_data,
  input  logic [ADDR_W-1:2] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              rsp_offpage
);

  localparam int WORD_LSB    = 2;
  localparam int ARR_AW      = ADDR_W - WORD_LSB;
  localparam int ARR_WORDS   = 2 ** ARR_AW;
  localparam int SH_WORDS    = SHADOW_BYTES / 4;
  localparam int SH_AW       = $clog2(SH_WORDS);
  localparam int RSV_WORDS   = RSV_BYTES / 4;
  localparam int PAGE_LSB    = $clog2(PAGE_BYTES);
  localparam int TAG_W       = ADDR_W - PAGE_LSB;
  localparam int CNT_W       = $clog2(EXTRA_WAIT + 1);

  // address arithmetic
  function automatic logic [ARR_AW-1:0] array_word(input logic [ADDR_W-1:2] a);
    return a[ADDR_W-1:WORD_LSB];
  endfunction

  function automatic logic [SH_AW-1:0] shadow_word(input logic [ADDR_W-1:2] a);
    return a[SH_AW+WORD_LSB-1:WORD_LSB];
  endfunction

  function automatic logic [TAG_W-1:0] page_of(input logic [ADDR_W-1:2] a);
    return a[ADDR_W-1:PAGE_LSB];
  endfunction

  function automatic logic shadow_reserved(input logic [SH_AW-1:0] w);
    return int'(w) < RSV_WORDS;
  endfunction

  // state
  xfer_state_e          st_q;
  logic [CNT_W-1:0]     cnt_q;
  resp_kind_e           kind_q;
  logic                 off_q;
  logic [CTRL_BITS-1:0] ctrl_snap_q;

  // control register
  logic alias_en, guard, pgm_en, alias_change;

  // request decode events
  logic accept, priv_ok, err_acc, rd_acc, wr_acc, ctrl_wr, ctrl_rd;
  logic arr_we, sh_we, arr_re, sh_re, mon_off, mon_flush;
  logic [SH_AW-1:0]  sh_idx;
  logic [DATA_W-1:0] arr_q, sh_q;

  assign accept  = (st_q == ST_IDLE) && req_valid;
  assign priv_ok = req_super && req_data;
  assign err_acc = accept && !req_ctrl && alias_en && !priv_ok;
  assign rd_acc  = accept && !req_ctrl && !req_write && !err_acc;
  assign wr_acc  = accept && !req_ctrl && req_write && !err_acc;
  assign ctrl_wr = accept && req_ctrl && req_write;
  assign ctrl_rd = accept && req_ctrl && !req_write;

  assign sh_idx    = shadow_word(req_addr);
  assign arr_we    = wr_acc && pgm_en && !alias_en;
  assign sh_we     = wr_acc && pgm_en && alias_en && !shadow_reserved(sh_idx);
  assign arr_re    = rd_acc && !alias_en;
  assign sh_re     = rd_acc && alias_en;
  assign mon_flush = alias_change || wr_acc;

  fa_ctrl_reg u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (ctrl_wr),
    .wr_val       (req_wdata[CTRL_BITS-1:0]),
    .alias_en     (alias_en),
    .guard        (guard),
    .pgm_en       (pgm_en),
    .alias_change (alias_change)
  );

  fa_page_mon #(.TAG_W(TAG_W)) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (mon_flush),
    .update    (rd_acc),
    .probe_tag (page_of(req_addr)),
    .off_page  (mon_off)
  );

  fa_sram #(.DEPTH(ARR_WORDS), .DW(DATA_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (arr_we),
    .waddr (array_word(req_addr)),
    .wdata (req_wdata),
    .re    (arr_re),
    .raddr (array_word(req_addr)),
    .q     (arr_q)
  );

  fa_sram #(.DEPTH(SH_WORDS), .DW(DATA_W)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (sh_we),
    .waddr (sh_idx),
    .wdata (req_wdata),
    .re    (sh_re),
    .raddr (sh_idx),
    .q     (sh_q)
  );

  // transfer sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      kind_q      <= RK_NONE;
      off_q       <= 1'b0;
      ctrl_snap_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            off_q       <= rd_acc && mon_off;
            ctrl_snap_q <= {pgm_en, guard, alias_en};
            if (err_acc)       kind_q <= RK_ERROR;
            else if (ctrl_rd)  kind_q <= RK_CTRL_RD;
            else if (arr_re)   kind_q <= RK_ARRAY_RD;
            else if (sh_re)    kind_q <= RK_SHADOW_RD;
            else               kind_q <= RK_WRITE;
            if (rd_acc && mon_off) begin
              st_q  <= ST_WAIT;
              cnt_q <= CNT_W'(EXTRA_WAIT);
            end else begin
              st_q <= ST_RESP;
            end
          end
        end
        ST_WAIT: begin
          if (cnt_q == CNT_W'(1)) st_q <= ST_RESP;
          cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (st_q == ST_RESP) begin
      case (kind_q)
        RK_CTRL_RD:   rsp_rdata = DATA_W'(ctrl_snap_q);
        RK_ARRAY_RD:  rsp_rdata = arr_q;
        RK_SHADOW_RD: rsp_rdata = sh_q;
        default:      rsp_rdata = '0;
      endcase
    end
  end

  assign rsp_ready   = (st_q == ST_RESP);
  assign rsp_err     = (st_q == ST_RESP) && (kind_q == RK_ERROR);
  assign rsp_offpage = (st_q == ST_RESP) && off_q;

  // R8: error responses carry no data
  p_err_nodata_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0));

  // R9: on-page reads answer on the next cycle
  p_onpage_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !mon_off) |=> rsp_ready);

  // R9: off-page reads are held back
  p_offpage_slow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && mon_off) |=> !rsp_ready);

  // R9: the ready strobe lasts one cycle
  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);

  // R11: an alias change forces the next lookup off-page
  p_flush_on_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
    alias_change |=> mon_off);

  // R7: reserved shadow words are never written
  p_reserved_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && !req_ctrl && shadow_reserved(sh_idx)) |-> !sh_we);

endmodule

// File: tb/flash_alias_ctl_tb.sv
module flash_alias_ctl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;

  localparam logic [31:0] DA1  = 32'h1111_0001;
  localparam logic [31:0] DA2  = 32'h2222_0002;
  localparam logic [31:0] DS1  = 32'hDEAD_0008;
  localparam logic [31:0] DS2  = 32'hC0DE_0014;
  localparam logic [31:0] DBAD = 32'hBAD0_0000;

  // op: 0 ctrl wr, 1 ctrl rd, 2 sup data wr, 3 sup data rd, 4 user rd, 5 fetch rd
  // {op[2:0], byte addr[9:0], wdata, expected data, expected offpage, expected err, req}
  localparam int NVEC = 31;
  localparam logic [82:0] VEC [NVEC] = '{
    {3'd1, 10'h000, 32'h0, 32'h0, 1'b0, 1'b0, 4'd1},   // R1 reset ctrl
    {3'd3, 10'h040, 32'h0, 32'h0, 1'b1, 1'b0, 4'd10},  // R10 first read off-page
    {3'd0, 10'h000, 32'h4, 32'h0, 1'b0, 1'b0, 4'd2},   // R2 program enable
    {3'd2, 10'h040, DA1,   32'h0, 1'b0, 1'b0, 4'd6},   // R6 array write
    {3'd2, 10'h044, DA2,   32'h0, 1'b0, 1'b0, 4'd6},   // R6 array write
    {3'd3, 10'h040, 32'h0, DA1,   1'b1, 1'b0, 4'd11},  // R11 write cleared monitor
    {3'd3, 10'h044, 32'h0, DA2,   1'b0, 1'b0, 4'd10},  // R10 same page
    {3'd3, 10'h060, 32'h0, 32'h0, 1'b1, 1'b0, 4'd10},  // R10 next page
    {3'd0, 10'h000, 32'h5, 32'h0, 1'b0, 1'b0, 4'd2},   // R2 alias on
    {3'd1, 10'h000, 32'h0, 32'h5, 1'b0, 1'b0, 4'd2},   // R2 ctrl reached under alias
    {3'd2, 10'h008, DS1,   32'h0, 1'b0, 1'b0, 4'd7},   // R7 reserved write
    {3'd2, 10'h150, DS2,   32'h0, 1'b0, 1'b0, 4'd6},   // R6 shadow word 20
    {3'd3, 10'h008, 32'h0, 32'h0, 1'b1, 1'b0, 4'd7},   // R7 reserved unchanged
    {3'd3, 10'h050, 32'h0, DS2,   1'b1, 1'b0, 4'd4},   // R4 alias word 20
    {3'd3, 10'h350, 32'h0, DS2,   1'b1, 1'b0, 4'd4},   // R4 alias word 20, page 26
    {3'd4, 10'h050, 32'h0, 32'h0, 1'b0, 1'b1, 4'd8},   // R8 user
    {3'd5, 10'h050, 32'h0, 32'h0, 1'b0, 1'b1, 4'd8},   // R8 fetch
    {3'd0, 10'h000, 32'h3, 32'h0, 1'b0, 1'b0, 4'd3},   // R3 guard on, pgm off
    {3'd0, 10'h000, 32'h2, 32'h0, 1'b0, 1'b0, 4'd3},   // R3 blocked alias clear
    {3'd1, 10'h000, 32'h0, 32'h3, 1'b0, 1'b0, 4'd3},   // R3 alias kept
    {3'd3, 10'h350, 32'h0, DS2,   1'b0, 1'b0, 4'd3},   // R3 still aliased, on-page
    {3'd0, 10'h000, 32'h6, 32'h0, 1'b0, 1'b0, 4'd3},   // R3 pre-write pgm was 0
    {3'd1, 10'h000, 32'h0, 32'h7, 1'b0, 1'b0, 4'd3},   // R3 alias kept, pgm set
    {3'd0, 10'h000, 32'h6, 32'h0, 1'b0, 1'b0, 4'd3},   // R3 now allowed
    {3'd1, 10'h000, 32'h0, 32'h6, 1'b0, 1'b0, 4'd2},   // R2 readback
    {3'd3, 10'h040, 32'h0, DA1,   1'b1, 1'b0, 4'd11},  // R11 alias change cleared
    {3'd3, 10'h044, 32'h0, DA2,   1'b0, 1'b0, 4'd5},   // R5 array data
    {3'd0, 10'h000, 32'h0, 32'h0, 1'b0, 1'b0, 4'd6},   // R6 pgm off
    {3'd2, 10'h040, DBAD,  32'h0, 1'b0, 1'b0, 4'd6},   // R6 ignored write
    {3'd3, 10'h040, 32'h0, DA1,   1'b1, 1'b0, 4'd6},   // R6 array unchanged
    {3'd3, 10'h150, 32'h0, 32'h0, 1'b1, 1'b0, 4'd6}    // R6 shadow write missed array
  };

  logic              clk;
  logic              rst_n;
  logic              req_valid, req_ctrl, req_write, req_super, req_data;
  logic [ADDR_W-1:2] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              rsp_ready;
  logic [DATA_W-1:0] rsp_rdata;
  logic              rsp_err, rsp_offpage;

  int checks = 0;
  int failures = 0;

  flash_alias_ctl u_dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ctrl (req_ctrl), .req_write (req_write),
    .req_super (req_super), .req_data (req_data), .req_addr (req_addr),
    .req_wdata (req_wdata), .rsp_ready (rsp_ready), .rsp_rdata (rsp_rdata),
    .rsp_err (rsp_err), .rsp_offpage (rsp_offpage)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [9:0] addr, input logic [31:0] wd,
                       output logic [31:0] rd, output logic off, output logic err,
                       output int lat);
    @(negedge clk);
    req_valid = 1'b1;
    req_ctrl  = (op <= 3'd1);
    req_write = (op == 3'd0) || (op == 3'd2);
    req_super = (op != 3'd4);
    req_data  = (op != 3'd5);
    req_addr  = addr[9:2];
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_ready && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    rd  = rsp_rdata;
    off = rsp_offpage;
    err = rsp_err;
  endtask

  initial begin
    logic [31:0] rd;
    logic off, err;
    int lat;
    req_valid = 0; req_ctrl = 0; req_write = 0; req_super = 1; req_data = 1;
    req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state of the response port
    check("R1 ready after reset", {31'b0, rsp_ready}, 32'h0);
    check("R1 rdata after reset", rsp_rdata, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [2:0]  op;
      logic [31:0] exp;
      logic        eoff, eerr;
      int          elat;
      op   = VEC[i][82:80];
      exp  = VEC[i][37:6];
      eoff = VEC[i][5];
      eerr = VEC[i][4];
      do_op(op, VEC[i][79:70], VEC[i][69:38], rd, off, err, lat);
      elat = (eoff && !eerr) ? 3 : 1;
      checks++;
      if (rd !== exp || off !== eoff || err !== eerr || lat != elat) begin
        failures++;
        $display("FAIL R%0d vec %0d actual data=%h off=%b err=%b lat=%0d expected data=%h off=%b err=%b lat=%0d",
                 VEC[i][3:0], i, rd, off, err, lat, exp, eoff, eerr, elat);
      end
    end

    // R1 reset in mid-run restores register, memories and monitor (R10)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_op(3'd1, 10'h000, 32'h0, rd, off, err, lat);
    check("R1 ctrl after second reset", rd, 32'h0);
    do_op(3'd3, 10'h044, 32'h0, rd, off, err, lat);
    check("R1 array cleared by reset", rd, 32'h0);
    check("R10 first read after reset off-page", {31'b0, off}, 32'h1);
    check("R9 off-page latency", lat, 3);
    do_op(3'd3, 10'h040, 32'h0, rd, off, err, lat);
    check("R9 on-page latency", lat, 1);
    check("R10 on-page flag", {31'b0, off}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule